// File: doc/BRIEF.md
# Data Watchpoint Comparator Bank

This block holds a small bank of debug comparators that watch the data accesses of a processor. Each comparator has a 32-bit comparand and its own control word. A comparator can match the address of an access, or the data value of an access at byte, halfword or word size. Comparator zero can also match a free-running cycle count that the core supplies. A value match is never reported on its own. It is qualified by the address match of one or two other comparators, which the control word names by index.

Software programs the bank through a simple indexed write port. A combinational read port returns the selected word. Every access observed on the data bus is evaluated in the cycle it is valid. Each comparator that hits raises a one-cycle pulse in the next cycle. When a hitting comparator has its emit bit set, a trace strobe is raised in the same cycle, carrying the low 16 bits of the access address. That strobe is what a trace packetiser would consume.

Top module: `watch_cmp_bank`

## Requirements
- R1: After reset, every comparand reads 0. Every control word reads 0, except bit 16, which reports the second-link capability. No match or trace strobe is raised.
- R2: Address mode applies when control bit 0 (enable) is 1 and bit 1 (value mode) is 0. If an access with `acc_valid` high has `acc_addr` equal to the comparand, then `match_o[i]` is high in the next cycle only.
- R3: A comparator whose enable bit is 0 never raises its match output, whatever its other fields hold.
- R4: In value mode (bit 1 = 1), control bits 5:4 select the compare width: 00 compares bits 7:0 of `acc_data` against the comparand, 01 compares bits 15:0, and 10 compares all 32 bits.
- R5: While bits 5:4 hold the reserved code 11, a value-mode comparator never matches.
- R6: A value match additionally requires that the comparator named by bits 11:8 reports an address match on the same access. An index beyond the last comparator never qualifies.
- R7: When the bank is built with second-link capability, bits 15:12 name a second comparator whose address match is also required. Without that capability, those bits read 0, writes to them are ignored, and no second qualification is applied.
- R8: Cycle mode exists on comparator 0 only. With bits 0 and 2 set and bit 1 clear, `match_o[0]` pulses in the cycle after `cycle_cnt` equals the comparand, independent of accesses. On other comparators bit 2 reads 0. With bit 1 set, bit 2 has no effect.
- R9: When an address or value hit occurs on a comparator with bit 3 (emit) set, `trc_valid_o` pulses in the same cycle as the match, and `trc_addr_o` carries `acc_addr[15:0]`.
- R10: Bit 16 of a control word is read-only. It reads 1 exactly when the bank is built with second-link capability.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | IW | Comparator index for read and write |
| cfg_sel | input | 1 | 0 selects the comparand, 1 selects the control word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected word (combinational) |
| acc_valid | input | 1 | Observed data access is valid this cycle |
| acc_addr | input | AW | Address of the observed access |
| acc_data | input | 32 | Data value of the observed access |
| cycle_cnt | input | CW | Free-running cycle count |
| match_o | output | N | Per-comparator match pulse |
| trc_valid_o | output | 1 | Trace address strobe |
| trc_addr_o | output | 16 | Low address bits for the trace strobe |

## Verification
The hardest case to reach is a value match that is qualified on both links. It needs three comparators at once: two in address mode that hit on the same access, and a third in value mode whose two link fields name them. The bench reaches this case by giving the second linked comparator the same comparand as the first. It then moves that comparand away, which shows that one missing link suppresses the value hit. It sweeps all four size codes against data patterns that differ in bit 0, 8, 16 or 31, with the address hitting and then missing. A second instance built without the second-link capability checks that the second link field reads as zero and that a single-link qualification is enough.

// File: rtl/watch_cmp_pkg.sv
package watch_cmp_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } vsize_e;

  typedef struct packed {
    logic [3:0] link1;
    logic [3:0] link0;
    vsize_e     vsize;
    logic       emit;
    logic       cyc;
    logic       vmode;
    logic       en;
  } wctrl_t;

  // Decode a written control word; fields a build lacks are forced to zero.
  function automatic wctrl_t ctrl_from_word(logic [31:0] w, logic cyc_ok, logic link1_ok);
    wctrl_t c;
    c.en    = w[0];
    c.vmode = w[1];
    c.cyc   = w[2] & cyc_ok;
    c.emit  = w[3];
    c.vsize = vsize_e'(w[5:4]);
    c.link0 = w[11:8];
    c.link1 = link1_ok ? w[15:12] : 4'd0;
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(wctrl_t c, logic cap);
    logic [31:0] w;
    w        = '0;
    w[0]     = c.en;
    w[1]     = c.vmode;
    w[2]     = c.cyc;
    w[3]     = c.emit;
    w[5:4]   = c.vsize;
    w[11:8]  = c.link0;
    w[15:12] = c.link1;
    w[16]    = cap;
    return w;
  endfunction

  function automatic logic [31:0] size_mask(vsize_e s);
    case (s)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      SZ_WORD: return 32'hFFFF_FFFF;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic value_equal(logic [31:0] a, logic [31:0] b, vsize_e s);
    return (s != SZ_RSVD) && (((a ^ b) & size_mask(s)) == 32'd0);
  endfunction

endpackage

// File: rtl/watch_cmp_regs.sv
module watch_cmp_regs
  import watch_cmp_pkg::*;
#(
  parameter int N     = 4,
  parameter bit LINK2 = 1'b1,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic          sel,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output wctrl_t        ctrl_o [N],
  output logic [31:0]   comp_o [N]
);

  for (genvar i = 0; i < N; i++) begin : g_ent
    localparam bit CYC_OK = (i == 0);
    wctrl_t      ctrl_q;
    logic [31:0] comp_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        comp_q <= '0;
      end else if (we && (idx == IW'(i))) begin
        if (sel) ctrl_q <= ctrl_from_word(wdata, CYC_OK, LINK2);
        else     comp_q <= wdata;
      end
    end

    assign ctrl_o[i] = ctrl_q;
    assign comp_o[i] = comp_q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (idx == IW'(i)) rdata = sel ? ctrl_to_word(ctrl_o[i], LINK2) : comp_o[i];
    end
  end

endmodule

// File: rtl/watch_cmp_lane.sv
module watch_cmp_lane
  import watch_cmp_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 32,
  parameter bit IS_ZERO = 1'b0
) (
  input  wctrl_t        ctrl,
  input  logic [31:0]   comp,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [31:0]   acc_data,
  input  logic [CW-1:0] cycle_cnt,
  output logic          addr_hit,
  output logic          val_cand,
  output logic          cyc_hit
);

  logic cyc_mode;

  assign cyc_mode = IS_ZERO && ctrl.cyc && !ctrl.vmode;
  assign addr_hit = ctrl.en && !ctrl.vmode && !cyc_mode && acc_valid
                    && (acc_addr == comp[AW-1:0]);
  assign val_cand = ctrl.en && ctrl.vmode && acc_valid
                    && value_equal(acc_data, comp, ctrl.vsize);
  assign cyc_hit  = ctrl.en && cyc_mode && (cycle_cnt == comp[CW-1:0]);

endmodule

// File: rtl/watch_cmp_link.sv
module watch_cmp_link #(
  parameter int N = 4
) (
  input  logic [N-1:0] addr_hits,
  input  logic [3:0]   sel,
  output logic         hit
);

  always_comb begin
    hit = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (sel == 4'(j)) hit = addr_hits[j];
    end
  end

endmodule

// File: rtl/watch_cmp_bank.sv
module watch_cmp_bank
  import watch_cmp_pkg::*;
#(
  parameter int N     = 4,
  parameter int AW    = 32,
  parameter int CW    = 32,
  parameter bit LINK2 = 1'b1,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic          cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [31:0]   acc_data,
  input  logic [CW-1:0] cycle_cnt,
  output logic [N-1:0]  match_o,
  output logic          trc_valid_o,
  output logic [15:0]   trc_addr_o
);

  wctrl_t      ctrl [N];
  logic [31:0] comp [N];

  logic [N-1:0]   addr_hit, val_cand, cyc_hit, l0_ok, l1_ok, val_hit, hit, emit_hit;
  logic [N-1:0]   en_vec, vmode_vec, cyc_vec, link1_nz;
  logic [2*N-1:0] size_vec;

  watch_cmp_regs #(.N(N), .LINK2(LINK2)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ctrl_o(ctrl), .comp_o(comp)
  );

  for (genvar i = 0; i < N; i++) begin : g_cmp
    watch_cmp_lane #(.AW(AW), .CW(CW), .IS_ZERO(i == 0)) lane_i (
      .ctrl(ctrl[i]), .comp(comp[i]), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_data(acc_data), .cycle_cnt(cycle_cnt),
      .addr_hit(addr_hit[i]), .val_cand(val_cand[i]), .cyc_hit(cyc_hit[i])
    );

    watch_cmp_link #(.N(N)) link0_i (.addr_hits(addr_hit), .sel(ctrl[i].link0), .hit(l0_ok[i]));
    watch_cmp_link #(.N(N)) link1_i (.addr_hits(addr_hit), .sel(ctrl[i].link1), .hit(l1_ok[i]));

    if (LINK2) begin : g_two
      assign val_hit[i] = val_cand[i] && l0_ok[i] && l1_ok[i];
    end else begin : g_one
      assign val_hit[i] = val_cand[i] && l0_ok[i];
    end

    assign hit[i]      = addr_hit[i] || val_hit[i] || cyc_hit[i];
    assign emit_hit[i] = (addr_hit[i] || val_hit[i]) && ctrl[i].emit;

    // Named views of the configuration for the checker.
    assign en_vec[i]         = ctrl[i].en;
    assign vmode_vec[i]      = ctrl[i].vmode;
    assign cyc_vec[i]        = ctrl[i].cyc;
    assign link1_nz[i]       = (ctrl[i].link1 != 4'd0);
    assign size_vec[2*i +: 2] = ctrl[i].vsize;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_o     <= '0;
      trc_valid_o <= 1'b0;
      trc_addr_o  <= '0;
    end else begin
      match_o     <= hit;
      trc_valid_o <= |emit_hit;
      trc_addr_o  <= (|emit_hit) ? acc_addr[15:0] : 16'd0;
    end
  end

endmodule

// File: rtl/watch_cmp_chk.sv
module watch_cmp_chk #(
  parameter int N     = 4,
  parameter bit LINK2 = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           acc_valid,
  input logic [N-1:0]   match_o,
  input logic           trc_valid_o,
  input logic [N-1:0]   en_vec,
  input logic [N-1:0]   vmode_vec,
  input logic [N-1:0]   cyc_vec,
  input logic [N-1:0]   link1_nz,
  input logic [2*N-1:0] size_vec,
  input logic [N-1:0]   l0_ok,
  input logic [N-1:0]   l1_ok
);

  for (genvar i = 0; i < N; i++) begin : g_a
    AST_OFF_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      match_o[i] |-> $past(en_vec[i])); // R3
    AST_RSVD_SIZE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o[i] && $past(vmode_vec[i])) |-> ($past(size_vec[2*i +: 2]) != 2'b11)); // R5
    AST_VALUE_NEEDS_LINK0: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o[i] && $past(vmode_vec[i])) |-> $past(l0_ok[i])); // R6
    if (LINK2) begin : g_l2
      AST_VALUE_NEEDS_LINK1: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o[i] && $past(vmode_vec[i])) |-> $past(l1_ok[i])); // R7
    end else begin : g_l1
      AST_LINK1_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !link1_nz[i]); // R7
    end
    if (i > 0) begin : g_nz
      AST_ACCESS_BEHIND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        match_o[i] |-> $past(acc_valid)); // R2
      AST_CYCLE_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_vec[i]); // R8
    end
  end

  AST_TRACE_WITH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    trc_valid_o |-> (|match_o)); // R9

endmodule

bind watch_cmp_bank watch_cmp_chk #(.N(N), .LINK2(LINK2)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .match_o(match_o),
  .trc_valid_o(trc_valid_o), .en_vec(en_vec), .vmode_vec(vmode_vec),
  .cyc_vec(cyc_vec), .link1_nz(link1_nz), .size_vec(size_vec),
  .l0_ok(l0_ok), .l1_ok(l1_ok)
);

// File: tb/watch_cmp_bank_tb_top.sv
module watch_cmp_bank_tb_top;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_a = 1'b0, we_b = 1'b0;
  logic [1:0]  idx = '0;
  logic        sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0, acc_data = '0, cyc = '0;
  logic [N-1:0] m_a, m_b;
  logic        tv_a, tv_b;
  logic [15:0] ta_a, ta_b;

  int checks = 0;
  int errors = 0;

  logic [31:0] sh_ctrl [N];
  logic [31:0] sh_comp [N];

  always #4 clk = ~clk;

  watch_cmp_bank #(.N(N), .LINK2(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_a), .cfg_idx(idx), .cfg_sel(sel),
    .cfg_wdata(wdata), .cfg_rdata(rd_a), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_data(acc_data), .cycle_cnt(cyc), .match_o(m_a), .trc_valid_o(tv_a), .trc_addr_o(ta_a)
  );

  watch_cmp_bank #(.N(N), .LINK2(1'b0)) dut_nc_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_b), .cfg_idx(idx), .cfg_sel(sel),
    .cfg_wdata(wdata), .cfg_rdata(rd_b), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_data(acc_data), .cycle_cnt(cyc), .match_o(m_b), .trc_valid_o(tv_b), .trc_addr_o(ta_b)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write to bank A (b=0) or bank B (b=1); shadow tracks bank A.
  task automatic wr(input bit b, input int i, input bit s, input logic [31:0] d);
    @(negedge clk);
    idx = 2'(i); sel = s; wdata = d;
    if (b) we_b = 1'b1; else we_a = 1'b1;
    @(negedge clk);
    we_a = 1'b0; we_b = 1'b0;
    if (!b) begin
      if (s) begin
        sh_ctrl[i] = d & 32'h0000_FF3F;
        if (i != 0) sh_ctrl[i][2] = 1'b0;
      end else sh_comp[i] = d;
    end
  endtask

  task automatic rd(input int i, input bit s, output logic [31:0] a, output logic [31:0] b);
    @(negedge clk);
    idx = 2'(i); sel = s;
    #1;
    a = rd_a; b = rd_b;
  endtask

  function automatic logic [31:0] mask_of(logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // Expected hits of bank A for one access (cycle input assumed not matching).
  function automatic logic [N-1:0] exp_hits(logic [31:0] a, logic [31:0] d);
    logic [N-1:0] ah, h;
    ah = '0; h = '0;
    for (int i = 0; i < N; i++) begin
      logic [31:0] c;
      c = sh_ctrl[i];
      ah[i] = c[0] && !c[1] && !(i == 0 && c[2]) && (a == sh_comp[i]);
    end
    for (int i = 0; i < N; i++) begin
      logic [31:0] c;
      int l0, l1;
      c = sh_ctrl[i];
      l0 = int'(c[11:8]); l1 = int'(c[15:12]);
      h[i] = ah[i] || (c[0] && c[1] && c[5:4] != 2'b11
             && ((d & mask_of(c[5:4])) == (sh_comp[i] & mask_of(c[5:4])))
             && l0 < N && ah[l0 % N] && l1 < N && ah[l1 % N]);
    end
    return h;
  endfunction

  task automatic access(input logic [31:0] a, input logic [31:0] d, input string req);
    logic [N-1:0] e;
    logic ev;
    e = exp_hits(a, d);
    ev = 1'b0;
    for (int i = 0; i < N; i++) if (e[i] && sh_ctrl[i][3]) ev = 1'b1;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_data = d;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(m_a == e, req, 32'(m_a), 32'(e));
    chk(tv_a == ev && (!ev || ta_a == a[15:0]), {req, "/R9 trace"},
        {15'd0, tv_a, ta_a}, {15'd0, ev, a[15:0]});
  endtask

  localparam logic [31:0] A = 32'h2000_0100;
  localparam logic [31:0] V = 32'h8A3C_5EF1;

  initial begin
    logic [31:0] ra, rb;
    logic [31:0] pats [5];
    for (int i = 0; i < N; i++) begin sh_ctrl[i] = '0; sh_comp[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1, R10: reset values and read-only capability bit
    for (int i = 0; i < N; i++) begin
      rd(i, 1'b1, ra, rb);
      chk(ra == 32'h0001_0000, "R1/R10 ctrl A", ra, 32'h0001_0000);
      chk(rb == 32'h0, "R1/R10 ctrl B", rb, 32'h0);
      rd(i, 1'b0, ra, rb);
      chk(ra == 32'h0 && rb == 32'h0, "R1 comparand", ra, 32'h0);
    end
    chk(m_a == '0 && !tv_a, "R1 outputs", 32'(m_a), 32'h0);
    wr(0, 2, 1'b1, 32'hFFFF_FFFF);
    rd(2, 1'b1, ra, rb);
    chk(ra == 32'h0001_FF3B, "R8/R10 ctrl readback", ra, 32'h0001_FF3B);

    // R2: address mode on comparator 1, emit on
    wr(0, 2, 1'b1, 32'h0);
    wr(0, 1, 1'b0, A);
    wr(0, 1, 1'b1, 32'h9);
    access(A, 32'h0, "R2 addr hit");
    @(negedge clk);
    chk(m_a == '0, "R2 single pulse", 32'(m_a), 32'h0);
    access(A + 4, 32'h0, "R2 addr miss");
    // R3: disabled comparator silent
    wr(0, 1, 1'b1, 32'h8);
    access(A, 32'h0, "R3 disabled");
    wr(0, 1, 1'b1, 32'h9);

    // R4, R5, R6: value mode sweep, linked to comparator 1 twice
    pats[0] = V; pats[1] = V ^ 32'h1; pats[2] = V ^ 32'h100;
    pats[3] = V ^ 32'h1_0000; pats[4] = V ^ 32'h8000_0000;
    wr(0, 2, 1'b0, V);
    for (int sz = 0; sz < 4; sz++) begin
      wr(0, 2, 1'b1, 32'h0000_110B | (32'(sz) << 4));
      for (int p = 0; p < 5; p++) begin
        access(A, pats[p], "R4/R5/R6 value sweep");
        access(A + 8, pats[p], "R6 value no link");
      end
    end

    // R7: second link to comparator 3
    wr(0, 2, 1'b1, 32'h0000_312B);
    wr(0, 3, 1'b0, A);
    wr(0, 3, 1'b1, 32'h1);
    access(A, V, "R7 both links hit");
    wr(0, 3, 1'b0, A + 8);
    access(A, V, "R7 second link misses");
    access(A + 8, V, "R7 first link misses");
    // R6: link index beyond last comparator
    wr(0, 2, 1'b1, 32'h0000_192B);
    access(A, V, "R6 out of range link");
    wr(0, 2, 1'b1, 32'h0);
    wr(0, 3, 1'b1, 32'h0);

    // R8: cycle mode on comparator 0
    wr(0, 0, 1'b0, 32'd50);
    wr(0, 0, 1'b1, 32'h5);
    for (int k = 40; k < 60; k++) begin
      @(negedge clk);
      cyc = 32'(k);
      @(negedge clk);
      chk(m_a[0] == (k == 50), "R8 cycle match", 32'(m_a), 32'(k == 50));
    end
    cyc = 32'd0;
    access(32'd50, 32'h0, "R8 cycle mode ignores address");
    wr(0, 1, 1'b1, 32'h5);
    rd(1, 1'b1, ra, rb);
    chk(ra == 32'h0001_0001, "R8 cycle bit absent on 1", ra, 32'h0001_0001);
    wr(0, 0, 1'b1, 32'h0000_0037);
    @(negedge clk); cyc = 32'd50;
    @(negedge clk);
    chk(m_a[0] == 1'b0, "R8 value mode overrides cycle", 32'(m_a), 32'h0);
    cyc = 32'd0;
    wr(0, 0, 1'b1, 32'h0);

    // R7: bank without second-link capability
    wr(1, 1, 1'b1, 32'h0000_F00B);
    rd(1, 1'b1, ra, rb);
    chk(rb == 32'h0000_000B, "R7 link1 ignored", rb, 32'h0000_000B);
    wr(1, 0, 1'b0, A);
    wr(1, 0, 1'b1, 32'h1);
    wr(1, 1, 1'b0, V);
    wr(1, 1, 1'b1, 32'h0000_302B);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = A; acc_data = V;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(m_b == 4'b0011, "R7 single link enough", 32'(m_b), 32'h3);
    chk(tv_b && ta_b == A[15:0], "R9 trace bank B", {15'd0, tv_b, ta_b}, {15'd0, 1'b1, A[15:0]});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule